// File: doc/BRIEF.md
# PRBS Test-Path Lane Selector

This block sits between eight receive framer lanes and one shared pseudo-random test pattern engine. Each cycle that a new bit is present, it qualifies that bit from its position in the frame: a timeslot index 0 to 23, index 24 for the framing bit, and a bit index 0 to 7 within the timeslot. One lane, chosen by a 3-bit select, is then either tapped toward the pattern detector or has its receive bit overwritten by generator output. Every other lane passes straight through.

Detect and generate each have their own framing and fractional settings. In unframed operation every timeslot and the framing bit take part. In framed operation only timeslots whose per-channel test flag is set take part. The fractional 56k option then also skips the last bit (bit index 7) of each such timeslot. The detector side is a registered valid/data strobe. It has no ready, so the detector must accept every strobe. The generator side is a ready/valid pair. `gen_ready` requests one bit, and that bit is used only if the generator holds `gen_valid` in the same cycle. The engine's sequence therefore advances only on qualified bits and stays continuous across skipped positions.

Top module: `tsp_prbs_tap`

## Requirements
- R1: After reset `det_valid` and `det_bit` are 0.
- R2: In detect direction the qualified bit of the lane numbered `lane_sel` appears on `det_bit`, with `det_valid` high, exactly one clock after it is presented. Otherwise `det_valid` and `det_bit` are 0.
- R3: `gen_dir`=0 selects detect and `gen_dir`=1 selects generate. `gen_ready` is never high in detect direction, and no detector strobe follows a generate-direction bit.
- R4: With the active direction's unframed setting at 1, every bit of slots 0..23 and of slot 24 (framing bit) qualifies, whatever `chan_test` holds.
- R5: With the active direction's unframed setting at 0, a bit qualifies only if its slot is below 24 and bit `chan_test[slot]` is 1. The framing bit never qualifies.
- R6: Detect uses only `det_unframed`/`det_frac`, and generate uses only `gen_unframed`/`gen_frac`. The other direction's settings have no effect.
- R7: In framed operation with the active direction's fractional setting at 1, bit index 7 of every slot is excluded. No detector strobe is made for it, and in generate direction the original bit is output.
- R8: With `chan_ctl_en` at 0, nothing qualifies in either direction.
- R9: Lanes other than `lane_sel` output their input bit in the same cycle, in every mode.
- R10: On the selected lane in generate direction, `gen_ready` is high exactly on qualified bits. The lane outputs `gen_bit` when `gen_ready` and `gen_valid` are both high, and its own input bit otherwise.
- R11: Nothing qualifies when `in_valid` is 0 or `slot_idx` is above 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A receive bit and its position are present this cycle |
| slot_idx | input | 5 | Timeslot 0..23, 24 = framing bit |
| bit_idx | input | 3 | Bit within timeslot, 7 = last bit |
| chan_test | input | 24 | Per-timeslot test flags, bit n for slot n |
| chan_ctl_en | input | 1 | Global enable of the test path |
| lane_sel | input | 3 | Lane connected to the pattern engine |
| gen_dir | input | 1 | 0 detect, 1 generate |
| det_unframed | input | 1 | Detect: 1 unframed, 0 framed |
| det_frac | input | 1 | Detect: fractional 56k |
| gen_unframed | input | 1 | Generate: 1 unframed, 0 framed |
| gen_frac | input | 1 | Generate: fractional 56k |
| rx_lane_in | input | 8 | Receive bit of each lane |
| rx_lane_out | output | 8 | Receive bit of each lane after insertion |
| det_valid | output | 1 | Detector strobe |
| det_bit | output | 1 | Detector data bit |
| gen_ready | output | 1 | Request for one generator bit |
| gen_valid | input | 1 | Generator bit present |
| gen_bit | input | 1 | Generator data bit |

## Verification
The bench uses the default build of eight lanes, 24 timeslots and 8 bits per slot, which is small enough to sweep every lane select, both directions and every framed, unframed and fractional combination, with the enable on and off. For each configuration it walks all 26 slot codes (including the framing bit and one invalid code) and all 8 bit positions. The other direction's framing setting is held opposite to the active one, and `in_valid` and `gen_valid` drop at fixed positions. The per-slot flag pattern is rotated with the lane number, so flagged and unflagged slots land on different positions in every pass.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef struct packed {
    logic unframed;
    logic frac;
  } tsp_mode_t;

  typedef enum logic {
    DIR_DETECT   = 1'b0,
    DIR_GENERATE = 1'b1
  } tsp_dir_e;
endpackage

// File: rtl/tsp_slot_qual.sv
module tsp_slot_qual
  import tsp_pkg::*;
#(
  parameter int NSLOT = 24,
  parameter int BITS  = 8,
  parameter int SLOTW = $clog2(NSLOT + 1),
  parameter int BITW  = $clog2(BITS)
) (
  input  tsp_mode_t          mode,
  input  logic [SLOTW-1:0]   slot_idx,
  input  logic [BITW-1:0]    bit_idx,
  input  logic [NSLOT-1:0]   chan_test,
  output logic               hit
);
  localparam logic [SLOTW-1:0] FSLOT   = SLOTW'(NSLOT);
  localparam logic [BITW-1:0]  LASTBIT = BITW'(BITS - 1);

  logic in_slot, flag, drop_lsb;

  always_comb begin
    in_slot  = (slot_idx < FSLOT);
    flag     = |(chan_test & (NSLOT'(1) << slot_idx));
    drop_lsb = mode.frac && (bit_idx == LASTBIT);
    if (mode.unframed)
      hit = (slot_idx <= FSLOT);
    else
      hit = in_slot && flag && !drop_lsb;
  end
endmodule

// File: rtl/tsp_lane_mux.sv
module tsp_lane_mux #(
  parameter int NLANE = 8,
  parameter int SELW  = $clog2(NLANE)
) (
  input  logic [SELW-1:0]  lane_sel,
  input  logic             take,
  input  logic             gen_bit,
  input  logic [NLANE-1:0] rx_lane_in,
  output logic [NLANE-1:0] rx_lane_out
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic sel_match;
    assign sel_match      = (lane_sel == SELW'(i));
    assign rx_lane_out[i] = (sel_match && take) ? gen_bit : rx_lane_in[i];
  end
endmodule

// File: rtl/tsp_det_tap.sv
module tsp_det_tap #(
  parameter int NLANE = 8,
  parameter int SELW  = $clog2(NLANE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [SELW-1:0]  lane_sel,
  input  logic [NLANE-1:0] rx_lane_in,
  output logic             det_valid,
  output logic             det_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_valid <= 1'b0;
      det_bit   <= 1'b0;
    end else begin
      det_valid <= hit;
      det_bit   <= hit ? rx_lane_in[lane_sel] : 1'b0;
    end
  end
endmodule

// File: rtl/tsp_prbs_tap.sv
module tsp_prbs_tap
  import tsp_pkg::*;
#(
  parameter int NLANE = 8,
  parameter int NSLOT = 24,
  parameter int BITS  = 8,
  parameter int SELW  = $clog2(NLANE),
  parameter int SLOTW = $clog2(NSLOT + 1),
  parameter int BITW  = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SLOTW-1:0] slot_idx,
  input  logic [BITW-1:0]  bit_idx,
  input  logic [NSLOT-1:0] chan_test,
  input  logic             chan_ctl_en,
  input  logic [SELW-1:0]  lane_sel,
  input  logic             gen_dir,
  input  logic             det_unframed,
  input  logic             det_frac,
  input  logic             gen_unframed,
  input  logic             gen_frac,
  input  logic [NLANE-1:0] rx_lane_in,
  output logic [NLANE-1:0] rx_lane_out,
  output logic             det_valid,
  output logic             det_bit,
  output logic             gen_ready,
  input  logic             gen_valid,
  input  logic             gen_bit
);
  localparam int NDIR = 2;

  tsp_mode_t       mode [NDIR];
  logic [NDIR-1:0] qual;
  logic            active, hit_det, hit_gen;

  assign mode[DIR_DETECT]   = '{unframed: det_unframed, frac: det_frac};
  assign mode[DIR_GENERATE] = '{unframed: gen_unframed, frac: gen_frac};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    tsp_slot_qual #(
      .NSLOT(NSLOT), .BITS(BITS), .SLOTW(SLOTW), .BITW(BITW)
    ) u_qual (
      .mode      (mode[d]),
      .slot_idx  (slot_idx),
      .bit_idx   (bit_idx),
      .chan_test (chan_test),
      .hit       (qual[d])
    );
  end

  assign active  = in_valid && chan_ctl_en;
  assign hit_det = active && (gen_dir == DIR_DETECT)   && qual[DIR_DETECT];
  assign hit_gen = active && (gen_dir == DIR_GENERATE) && qual[DIR_GENERATE];
  assign gen_ready = hit_gen;

  tsp_lane_mux #(.NLANE(NLANE), .SELW(SELW)) u_mux (
    .lane_sel    (lane_sel),
    .take        (hit_gen && gen_valid),
    .gen_bit     (gen_bit),
    .rx_lane_in  (rx_lane_in),
    .rx_lane_out (rx_lane_out)
  );

  tsp_det_tap #(.NLANE(NLANE), .SELW(SELW)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit_det),
    .lane_sel   (lane_sel),
    .rx_lane_in (rx_lane_in),
    .det_valid  (det_valid),
    .det_bit    (det_bit)
  );
endmodule

// File: rtl/tsp_prbs_tap_chk.sv
module tsp_prbs_tap_chk #(
  parameter int NLANE = 8,
  parameter int NSLOT = 24,
  parameter int BITS  = 8,
  parameter int SELW  = $clog2(NLANE),
  parameter int SLOTW = $clog2(NSLOT + 1),
  parameter int BITW  = $clog2(BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [SLOTW-1:0] slot_idx,
  input logic [BITW-1:0]  bit_idx,
  input logic             chan_ctl_en,
  input logic [SELW-1:0]  lane_sel,
  input logic             gen_dir,
  input logic             gen_unframed,
  input logic             gen_frac,
  input logic [NLANE-1:0] rx_lane_in,
  input logic [NLANE-1:0] rx_lane_out,
  input logic             det_valid,
  input logic             det_bit,
  input logic             gen_ready
);
  logic [NLANE-1:0] others;
  assign others = ~(NLANE'(1) << lane_sel);

  // R3
  gen_dir_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ready |-> gen_dir);

  // R3
  no_det_in_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_dir |=> !det_valid);

  // R8
  ctl_off_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_ctl_en |=> !det_valid);

  // R8
  ctl_off_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_ctl_en |-> !gen_ready);

  // R11
  idle_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !det_valid);

  // R2
  det_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_valid |-> !det_bit);

  // R9
  others_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_lane_out ^ rx_lane_in) & others) == '0);

  // R10
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_lane_out ^ rx_lane_in));

  // R10
  no_touch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ready |-> rx_lane_out == rx_lane_in);

  // R7
  frac_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_dir && !gen_unframed && gen_frac && bit_idx == BITW'(BITS - 1))
      |-> !gen_ready);
endmodule

bind tsp_prbs_tap tsp_prbs_tap_chk #(
  .NLANE(NLANE), .NSLOT(NSLOT), .BITS(BITS),
  .SELW(SELW), .SLOTW(SLOTW), .BITW(BITW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot_idx(slot_idx),
  .bit_idx(bit_idx), .chan_ctl_en(chan_ctl_en), .lane_sel(lane_sel),
  .gen_dir(gen_dir), .gen_unframed(gen_unframed), .gen_frac(gen_frac),
  .rx_lane_in(rx_lane_in), .rx_lane_out(rx_lane_out),
  .det_valid(det_valid), .det_bit(det_bit), .gen_ready(gen_ready)
);

// File: tb/tsp_prbs_tap_tb.sv
module tsp_prbs_tap_tb;
  localparam int NLANE = 8;
  localparam int NSLOT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] slot_idx = '0;
  logic [2:0] bit_idx = '0;
  logic [NSLOT-1:0] chan_test = '0;
  logic chan_ctl_en = 1'b0;
  logic [2:0] lane_sel = '0;
  logic gen_dir = 1'b0;
  logic det_unframed = 1'b0, det_frac = 1'b0;
  logic gen_unframed = 1'b0, gen_frac = 1'b0;
  logic [NLANE-1:0] rx_lane_in = '0;
  logic [NLANE-1:0] rx_lane_out;
  logic det_valid, det_bit, gen_ready;
  logic gen_valid = 1'b0, gen_bit = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tsp_prbs_tap u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic pend_v, pend_b;
    string pend_tag;
    pend_v = 0; pend_b = 0; pend_tag = "R2";
    repeat (3) @(negedge clk);
    #1;
    chk("R1 det_valid", det_valid, 0);
    chk("R1 det_bit", det_bit, 0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 128; cfg++) begin
      int lane, unf, frac;
      lane = cfg & 7;
      gen_dir = cfg[3];
      unf = cfg[4];
      frac = cfg[5];
      chan_ctl_en = cfg[6];
      lane_sel = 3'(lane);
      // R6: the inactive direction holds the opposite framing setting
      det_unframed = gen_dir ? !unf[0] : unf[0];
      gen_unframed = gen_dir ? unf[0] : !unf[0];
      det_frac = gen_dir ? !frac[0] : frac[0];
      gen_frac = gen_dir ? frac[0] : !frac[0];
      chan_test = NSLOT'(24'hA5C396 << lane) | NSLOT'(24'hA5C396 >> (NSLOT - lane));
      for (int s = 0; s < 26; s++) begin
        for (int b = 0; b < 8; b++) begin
          logic iv, tap, exp_out;
          string tag;
          @(negedge clk);
          #1;
          chk(pend_tag, {det_valid, det_bit}, {pend_v, pend_b});
          iv = !(b == 5 && (s % 3) == 0);
          in_valid = iv;
          slot_idx = 5'(s);
          bit_idx = 3'(b);
          rx_lane_in = NLANE'((s * 37 + b * 11 + cfg * 5) ^ (s << 3));
          gen_valid = (b != 3);
          gen_bit = ((s + b + cfg) % 3) == 1;
          if (unf != 0) tap = (s <= 24);
          else tap = (s < 24) && chan_test[s % NSLOT] && !(frac != 0 && b == 7);
          tap = tap && iv && chan_ctl_en;
          if (!chan_ctl_en) tag = "R8";
          else if (!iv || s > 24) tag = "R11";
          else if (unf != 0) tag = "R4";
          else if (frac != 0 && b == 7) tag = "R7";
          else tag = "R5";
          #1;
          chk({tag, " R10 gen_ready"}, gen_ready, (tap && gen_dir) ? 1 : 0);
          exp_out = (tap && gen_dir && gen_valid) ? gen_bit : rx_lane_in[lane];
          chk({tag, " R10 lane"}, rx_lane_out[lane], exp_out);
          chk("R9 others", int'(rx_lane_out & ~(NLANE'(1) << lane)),
              int'(rx_lane_in & ~(NLANE'(1) << lane)));
          pend_v = tap && !gen_dir;
          pend_b = pend_v ? rx_lane_in[lane] : 1'b0;
          pend_tag = gen_dir ? "R3 det" : {tag, " R2 det"};
        end
      end
    end
    @(negedge clk);
    #1;
    chk(pend_tag, {det_valid, det_bit}, {pend_v, pend_b});
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 det_valid reset", det_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule